// File: doc/BRIEF.md
# Two-Way Instruction Cache Lookup

This block is a two-way set-associative instruction cache with 128 sets of four-word lines. A core-side port presents one fetch address at a time. The block returns the addressed 32-bit word one cycle after acceptance on a hit. On a miss it requests a four-word burst from a bus-side port. The bus returns the missing word first and then wraps around the line. The core gets its word as soon as that first beat arrives.

Two single-line buffers sit in front of the tag and data arrays. One holds the last line read out of the array; the other holds the last line received from the bus. A fetch that finds its line in either buffer is a hit, and the array stays idle, which is shown on a dedicated output. Lines may be pinned by fetching them with a lock flag. A fill picks its way in this order: an invalid way first, then the least recently used way, and never a locked way. When both ways of the indexed set are locked, the fill feeds only the burst buffer.

Top module: `icache2w`

## Requirements
- R1: After reset no line is valid or locked, both buffers are empty, `req_ready` is 1, and `rsp_valid`, `bus_req` and `arr_rd` are 0, so the first fetch is a miss.
- R2: The address splits into a tag in bits [31:11], a set index in bits [10:4] and a word select in bits [3:2]. A hit needs a valid way whose tag matches. On a hit the selected word appears on `rsp_data` with `rsp_valid` 1 in the cycle after acceptance, and no bus request is made.
- R3: A fetch with `req_lock` 0 whose line address (bits [31:4]) equals that of the line buffer or the burst buffer is served from that buffer one cycle after acceptance.
- R4: `arr_rd` is 1 in the acceptance cycle exactly when the lookup reads the array: on a buffer hit it is 0, otherwise it is 1.
- R5: On a miss `bus_req` rises the cycle after acceptance and stays high with `bus_addr` equal to the fetch address (bits [1:0] cleared) until four `bus_rvalid` beats have arrived. Beat k carries word (crit+k) mod 4, where crit is fetch bits [3:2]. The core receives beat 0 in the next cycle, and `req_ready` stays 0 until the cycle after the last beat.
- R6: A fill writes an invalid way of the set if there is one, way 0 before way 1.
- R7: When both ways are valid and unlocked, the fill replaces the way that was not the most recently hit or filled in that set.
- R8: A fetch with `req_lock` 1 skips both buffers and reads the array. It locks the line it hits or fills. A locked way is never replaced, so a miss in a set with one locked way replaces the other way.
- R9: If both ways of the set are valid and locked, a miss is served from the bus into the burst buffer only. The array is not written, and a later fetch of that line misses again once the burst buffer holds another line.
- R10: When a fill completes, the burst buffer holds the whole new line in word order, so that every word of it hits from the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request present |
| req_lock | input | 1 | Lock the fetched line; skip the buffers |
| req_addr | input | 32 | Fetch byte address |
| req_ready | output | 1 | Block can accept a fetch this cycle |
| arr_rd | output | 1 | The array is read for the accepted fetch |
| rsp_valid | output | 1 | Fetched word valid |
| rsp_data | output | 32 | Fetched word |
| bus_req | output | 1 | Burst read request, held during the fill |
| bus_addr | output | 32 | Word address of the missed fetch |
| bus_rvalid | input | 1 | Burst beat valid |
| bus_rdata | input | 32 | Burst beat data |

## Verification
Two functions share a cycle in two ways. Completing a fill updates the burst buffer, the victim way, its LRU bit and its lock bit at one edge, and the very next fetch looks up that same set. A lock request also arrives while the burst buffer still holds the line, so the buffer bypass and the lock update happen in the same acceptance cycle. The bench provokes both by issuing a fetch to the just-filled line as soon as `req_ready` returns, and by locking lines that are still sitting in a buffer. It judges the outcome from `arr_rd`, from the count of bus requests, and from later fetches that reveal which way survived.

// File: rtl/icache2w.sv
module icache2w #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int IDX_W = 7,
  parameter int OFF_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_lock,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic          arr_rd,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  input  logic          bus_rvalid,
  input  logic [DW-1:0] bus_rdata
);
  localparam int SETS  = 1 << IDX_W;
  localparam int WORDS = 1 << OFF_W;
  localparam int LA_W  = AW - 2 - OFF_W;
  localparam int TAG_W = LA_W - IDX_W;

  typedef enum logic {S_IDLE, S_FILL} st_t;
  st_t state;

  logic [TAG_W-1:0] tags   [2][SETS];
  logic [DW-1:0]    lines  [2][SETS][WORDS];
  logic [1:0]       vld    [SETS];
  logic [1:0]       lck    [SETS];
  logic [SETS-1:0]  lru;

  logic [LA_W-1:0]  lb_la, bb_la, f_la;
  logic             lb_v, bb_v, f_lock;
  logic [DW-1:0]    lb_data [WORDS];
  logic [DW-1:0]    bb_data [WORDS];
  logic [DW-1:0]    fill_line [WORDS];
  logic [OFF_W-1:0] f_crit, cnt, bw;

  logic [LA_W-1:0]  la;
  logic [IDX_W-1:0] idx, fi;
  logic [TAG_W-1:0] tag;
  logic [OFF_W-1:0] wsel;
  logic             accept, lb_hit, bb_hit, hit0, hit1, ahit, hway;
  logic             last, vic_ok, vw;
  logic [1:0]       fv, fk;

  assign la     = req_addr[AW-1:2+OFF_W];
  assign idx    = la[IDX_W-1:0];
  assign tag    = la[LA_W-1:IDX_W];
  assign wsel   = req_addr[2+:OFF_W];
  assign req_ready = (state == S_IDLE);
  assign accept = req_valid && req_ready;
  assign lb_hit = lb_v && (lb_la == la) && !req_lock;
  assign bb_hit = bb_v && (bb_la == la) && !req_lock;
  assign arr_rd = accept && !lb_hit && !bb_hit;
  assign hit0   = vld[idx][0] && (tags[0][idx] == tag);
  assign hit1   = vld[idx][1] && (tags[1][idx] == tag);
  assign ahit   = hit0 || hit1;
  assign hway   = hit1;

  assign bus_req  = (state == S_FILL);
  assign bus_addr = {f_la, f_crit, 2'b00};
  assign bw       = f_crit + cnt;
  assign last     = bus_req && bus_rvalid && (cnt == OFF_W'(WORDS - 1));
  assign fi       = f_la[IDX_W-1:0];
  assign fv       = vld[fi];
  assign fk       = lck[fi];

  always_comb begin
    fill_line = bb_data;
    fill_line[bw] = bus_rdata;
  end

  always_comb begin
    vic_ok = 1'b1;
    vw = 1'b0;
    if (!fv[0])          vw = 1'b0;
    else if (!fv[1])     vw = 1'b1;
    else if (fk == 2'b11) vic_ok = 1'b0;
    else if (fk[0])      vw = 1'b1;
    else if (fk[1])      vw = 1'b0;
    else                 vw = lru[fi];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      rsp_valid <= 1'b0;
      rsp_data <= '0;
      lb_v <= 1'b0;
      bb_v <= 1'b0;
      lb_la <= '0;
      bb_la <= '0;
      f_la <= '0;
      f_crit <= '0;
      f_lock <= 1'b0;
      cnt <= '0;
      lru <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld[s] <= '0;
        lck[s] <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      if (state == S_IDLE) begin
        if (accept) begin
          if (bb_hit) begin
            rsp_valid <= 1'b1;
            rsp_data <= bb_data[wsel];
          end else if (lb_hit) begin
            rsp_valid <= 1'b1;
            rsp_data <= lb_data[wsel];
          end else if (ahit) begin
            rsp_valid <= 1'b1;
            rsp_data <= lines[hway][idx][wsel];
            lb_v <= 1'b1;
            lb_la <= la;
            lru[idx] <= ~hway;
            if (req_lock) lck[idx][hway] <= 1'b1;
          end else begin
            state <= S_FILL;
            f_la <= la;
            f_crit <= wsel;
            f_lock <= req_lock;
            cnt <= '0;
            bb_v <= 1'b0;
          end
        end
      end else if (bus_rvalid) begin
        cnt <= cnt + 1'b1;
        if (cnt == '0) begin
          rsp_valid <= 1'b1;
          rsp_data <= bus_rdata;
        end
        if (last) begin
          state <= S_IDLE;
          bb_v <= 1'b1;
          bb_la <= f_la;
          if (lb_v && lb_la == f_la) lb_v <= 1'b0;
          if (vic_ok) begin
            vld[fi][vw] <= 1'b1;
            lck[fi][vw] <= f_lock;
            lru[fi] <= ~vw;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (bus_req && bus_rvalid) bb_data[bw] <= bus_rdata;
    if (accept && !lb_hit && !bb_hit && ahit) lb_data <= lines[hway][idx];
    if (last && vic_ok) begin
      tags[vw][fi] <= f_la[LA_W-1:IDX_W];
      lines[vw][fi] <= fill_line;
    end
  end

  // R2
  array_hit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !lb_hit && !bb_hit && ahit |=> rsp_valid && !bus_req);

  // R5
  fill_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && $past(bus_req) |-> $stable(bus_addr));

  // R5
  fill_ends_on_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> $past(bus_rvalid));

  // R6
  invalid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last && vic_ok && (fv != 2'b11) |-> !fv[vw]);

  // R8
  no_locked_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last && vic_ok |-> !(fv[vw] && fk[vw]));

  // R9
  both_locked_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last && (fv == 2'b11) && (fk == 2'b11) |=> (vld[fi] == 2'b11) && (lck[fi] == 2'b11));
endmodule

// File: tb/icache2w_bench.sv
module icache2w_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_lock = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready, arr_rd, rsp_valid, bus_req;
  logic [31:0] rsp_data, bus_addr;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  int nbus = 0;
  int cyc = 0;
  logic [31:0] last_baddr = '0;

  always #4 clk = ~clk;

  icache2w u_icache2w (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lock(req_lock),
    .req_addr(req_addr), .req_ready(req_ready), .arr_rd(arr_rd),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] mem(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_C3C3;
  endfunction

  function automatic logic [31:0] mk(input int t, input int s, input int w);
    return {21'(t), 7'(s), 2'(w), 2'b00};
  endfunction

  task automatic check(input logic ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  initial begin
    bus_rvalid = 1'b0;
    bus_rdata = '0;
    forever begin
      @(negedge clk);
      if (bus_req) begin
        nbus++;
        last_baddr = bus_addr;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
          bus_rvalid = 1'b1;
          bus_rdata = mem({last_baddr[31:4], 2'(last_baddr[3:2] + 2'(k)), 2'b00});
          @(negedge clk);
        end
        bus_rvalid = 1'b0;
      end
    end
  end

  task automatic fetch(input logic [31:0] a, input logic lk, input logic exp_miss,
                       input int exp_arr, input string rq);
    int b0;
    int n;
    b0 = nbus;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_lock = lk;
    #1;
    if (exp_arr >= 0)
      check(arr_rd == exp_arr[0], rq, "arr_rd", 32'(arr_rd), 32'(exp_arr));
    @(negedge clk);
    req_valid = 1'b0; req_lock = 1'b0;
    n = 0;
    while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
    check(rsp_valid && rsp_data == mem(a), rq, "rsp_data", rsp_data, mem(a));
    if (!exp_miss)
      check(n == 0, rq, "hit latency", 32'(n), 0);
    else
      check(!req_ready, rq, "ready low during fill", 32'(req_ready), 0);
    n = 0;
    while (!req_ready && n < 100) begin @(negedge clk); n++; end
    check((nbus - b0) == int'(exp_miss), rq, "bus requests", 32'(nbus - b0), 32'(exp_miss));
    if (exp_miss)
      check(last_baddr == {a[31:2], 2'b00}, rq, "bus_addr", last_baddr, {a[31:2], 2'b00});
  endtask

  task automatic t_reset;
    #1;
    check(req_ready && !rsp_valid && !bus_req && !arr_rd, "R1", "idle outputs",
          {req_ready, rsp_valid, bus_req, arr_rd}, 32'b1000);
    fetch(mk(1, 5, 2), 1'b0, 1'b1, 1, "R1");
  endtask

  task automatic t_buffers;
    fetch(mk(1, 5, 0), 1'b0, 1'b0, 0, "R3 R10 burst buffer");
    fetch(mk(2, 5, 3), 1'b0, 1'b1, 1, "R6 second way");
    fetch(mk(1, 5, 1), 1'b0, 1'b0, 1, "R2 R4 array hit");
    fetch(mk(1, 5, 3), 1'b0, 1'b0, 0, "R3 R4 line buffer");
  endtask

  task automatic t_lru;
    fetch(mk(3, 5, 0), 1'b0, 1'b1, 1, "R7 evict lru");
    fetch(mk(2, 5, 0), 1'b0, 1'b1, 1, "R7 lru victim gone");
    fetch(mk(3, 5, 1), 1'b0, 1'b0, 1, "R7 mru kept");
    fetch(mk(1, 5, 0), 1'b0, 1'b1, -1, "R7 older evicted");
  endtask

  task automatic t_lock;
    fetch(mk(1, 5, 0), 1'b1, 1'b0, 1, "R8 lock bypasses buffer");
    fetch(mk(4, 5, 0), 1'b0, 1'b1, 1, "R8 fill");
    fetch(mk(5, 5, 0), 1'b0, 1'b1, 1, "R8 lru way locked");
    fetch(mk(1, 5, 0), 1'b1, 1'b0, 1, "R8 locked survives");
    fetch(mk(4, 5, 0), 1'b0, 1'b1, 1, "R8 unlocked way replaced");
  endtask

  task automatic t_both_locked;
    fetch(mk(4, 5, 2), 1'b1, 1'b0, 1, "R8 lock second way");
    fetch(mk(6, 5, 1), 1'b0, 1'b1, 1, "R9 miss both locked");
    fetch(mk(6, 5, 3), 1'b0, 1'b0, 0, "R9 burst buffer only");
    fetch(mk(7, 9, 0), 1'b0, 1'b1, 1, "R9 other set");
    fetch(mk(6, 5, 1), 1'b0, 1'b1, 1, "R9 not written");
    fetch(mk(1, 5, 0), 1'b1, 1'b0, 1, "R9 way0 kept");
    fetch(mk(4, 5, 0), 1'b1, 1'b0, 1, "R9 way1 kept");
  endtask

  task automatic t_wrap;
    fetch(mk(8, 11, 3), 1'b0, 1'b1, 1, "R5 critical word last slot");
    fetch(mk(8, 11, 0), 1'b0, 1'b0, 0, "R5 R10 wrap word0");
    fetch(mk(8, 11, 1), 1'b0, 1'b0, 0, "R5 R10 wrap word1");
    fetch(mk(8, 11, 2), 1'b0, 1'b0, 0, "R5 R10 wrap word2");
    fetch(mk(8, 11, 2), 1'b1, 1'b0, 1, "R2 array word2");
    fetch(mk(8, 11, 0), 1'b1, 1'b0, 1, "R2 array word0");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_buffers();
    t_lru();
    t_lock();
    t_both_locked();
    t_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule